// File: doc/BRIEF.md
# Variable-Clock Sequential Delay-Test Sequencer

This block drives a delay test of a sequential circuit that has no scan access. It holds a sequence of N input vectors, each paired with the output value the circuit should then show, and replays the whole sequence N times. On pass k (counting from 0), every vector except vector k is given a slow slot. The circuit-under-test clock enable pulses once at the end of that slot, which leaves the logic ample time to settle. Vector k is given a single undivided system cycle, so that one step runs at the rated clock and activates the paths being timed. The slow vectors ahead of it bring the circuit into a known state, and the slow vectors after it carry any captured fault effect out to the primary outputs.

The rated-clock position moves forward one vector per pass. A complete run therefore costs N*((N-1)*D+1) system cycles, which grows with the square of the sequence length. Vectors and expected outputs are written through a load port while the sequencer is idle. Whenever the tester raises a strobe during a run, a small checker compares the circuit outputs against the expected value of the current vector and records any mismatch in a sticky fail flag.

Top module: `vct_sequencer`

## Requirements
- R1: After reset the block is idle: busy, done, fail, fast flag and clock enable are 0, and the vector output, pass and index are 0.
- R2: A start pulse while not busy begins a run with pass 0, index 0 and the fail flag cleared, and busy rises in the following cycle. A start pulse during a run is ignored.
- R3: On pass k, vector k takes a single cycle in which the fast flag and the clock enable are both 1. The fast flag is never 1 in two consecutive cycles.
- R4: Every other vector takes a slow slot of SLOW_DIV cycles with the fast flag at 0. The clock enable is 1 only in the last cycle of that slot.
- R5: Each clock-enable cycle advances the index by one. After index N-1 the index returns to 0 and the pass advances by one.
- R6: The cycle after the clock enable of vector N-1 on pass N-1, done is 1 and busy is 0, exactly N*((N-1)*SLOW_DIV+1) cycles after busy rose. Done holds until the next start.
- R7: While busy, the vector output shows the stored vector at the current index. When not busy, it is 0.
- R8: A load write while not busy stores the vector and the expected output at the given address. A load write during a run is ignored.
- R9: A strobe during a run whose observed outputs differ from the expected value at the current index sets the sticky fail flag. A strobe while not busy has no effect on the flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start a run (accepted when not busy) |
| ld_we_i | input | 1 | Load-port write enable |
| ld_addr_i | input | IDX_W | Load-port vector address |
| ld_vec_i | input | VEC_W | Input vector to store |
| ld_exp_i | input | OUT_W | Expected output to store |
| strobe_i | input | 1 | Compare the observed outputs this cycle |
| cut_out_i | input | OUT_W | Observed outputs of the circuit under test |
| cut_clk_en_o | output | 1 | Clock enable for the circuit under test |
| fast_o | output | 1 | Current vector runs at the rated clock |
| cut_vec_o | output | VEC_W | Vector driven onto the circuit inputs |
| pass_o | output | IDX_W | Current pass number |
| idx_o | output | IDX_W | Current vector index |
| busy_o | output | 1 | Run in progress |
| done_o | output | 1 | Run complete |
| fail_o | output | 1 | Sticky strobe-mismatch flag |

## Verification
The assertions assume that load addresses stay below NUM_VEC and that the tester raises the strobe only when the circuit outputs belong to the vector currently applied. The stimulus uses only in-range addresses and draws random vectors, expected values and strobe timing from a seeded generator. It corrupts the observed output at exactly one chosen pass and index, and it makes deliberate load and start attempts in the middle of a run, so that the ignore rules are exercised without leaving those input limits.

// File: rtl/vct_pkg.sv
package vct_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_DONE = 2'd2
  } seq_state_e;
endpackage

// File: rtl/vct_vec_mem.sv
module vct_vec_mem #(
  parameter int NUM_VEC = 6,
  parameter int VEC_W   = 8,
  parameter int OUT_W   = 4,
  localparam int IDX_W  = $clog2(NUM_VEC)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic             lock_i,
  input  logic [IDX_W-1:0] waddr_i,
  input  logic [VEC_W-1:0] wvec_i,
  input  logic [OUT_W-1:0] wexp_i,
  input  logic [IDX_W-1:0] raddr_i,
  output logic [VEC_W-1:0] rvec_o,
  output logic [OUT_W-1:0] rexp_o
);
  logic [VEC_W-1:0] vec_q [NUM_VEC];
  logic [OUT_W-1:0] exp_q [NUM_VEC];
  logic             wr_ok;

  assign wr_ok = we_i && !lock_i && (int'(waddr_i) < NUM_VEC);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NUM_VEC; i++) begin
        vec_q[i] <= '0;
        exp_q[i] <= '0;
      end
    end else if (wr_ok) begin
      vec_q[waddr_i] <= wvec_i;
      exp_q[waddr_i] <= wexp_i;
    end
  end

  assign rvec_o = vec_q[raddr_i];
  assign rexp_o = exp_q[raddr_i];

  // a write attempt during a run leaves the slot untouched
  assert_locked_write_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && lock_i && (int'(waddr_i) < NUM_VEC)) |=>
      (vec_q[$past(waddr_i)] == $past(vec_q[waddr_i])))
    else $error("locked write changed storage");
endmodule

// File: rtl/vct_slot_timer.sv
module vct_slot_timer #(
  parameter int SLOW_DIV = 4,
  localparam int DIV_W   = $clog2(SLOW_DIV)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  input  logic fast_i,
  output logic tick_o
);
  localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(SLOW_DIV - 1);

  logic [DIV_W-1:0] div_q;

  assign tick_o = run_i && (fast_i || (div_q == DIV_LAST));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                div_q <= '0;
    else if (!run_i || tick_o)  div_q <= '0;
    else                        div_q <= div_q + 1'b1;
  end

  assert_div_range_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    div_q <= DIV_LAST)
    else $error("slot divider out of range");

  assert_slow_count_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && !tick_o) |=> (div_q == $past(div_q) + 1'b1))
    else $error("slow slot did not count");
endmodule

// File: rtl/vct_seq_ctrl.sv
module vct_seq_ctrl #(
  parameter int NUM_VEC = 6,
  localparam int IDX_W  = $clog2(NUM_VEC)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             tick_i,
  output logic             start_ok_o,
  output logic             busy_o,
  output logic             done_o,
  output logic             fast_o,
  output logic [IDX_W-1:0] pass_o,
  output logic [IDX_W-1:0] idx_o
);
  import vct_pkg::*;

  localparam logic [IDX_W-1:0] LAST = IDX_W'(NUM_VEC - 1);

  seq_state_e       state_q;
  logic [IDX_W-1:0] pass_q, idx_q;

  assign busy_o     = (state_q == ST_RUN);
  assign done_o     = (state_q == ST_DONE);
  assign start_ok_o = start_i && !busy_o;
  assign fast_o     = busy_o && (idx_q == pass_q);
  assign pass_o     = pass_q;
  assign idx_o      = idx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      pass_q  <= '0;
      idx_q   <= '0;
    end else if (start_ok_o) begin
      state_q <= ST_RUN;
      pass_q  <= '0;
      idx_q   <= '0;
    end else if (busy_o && tick_i) begin
      if (idx_q == LAST) begin
        idx_q <= '0;
        if (pass_q == LAST) begin
          pass_q  <= '0;
          state_q <= ST_DONE;
        end else begin
          pass_q <= pass_q + 1'b1;
        end
      end else begin
        idx_q <= idx_q + 1'b1;
      end
    end
  end

  assert_start_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o) |=> (busy_o && idx_q == '0 && pass_q == '0))
    else $error("start not taken");

  assert_step_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && tick_i && idx_q != LAST) |=>
      (idx_q == $past(idx_q) + 1'b1 && pass_q == $past(pass_q)))
    else $error("index did not step");

  assert_wrap_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && tick_i && idx_q == LAST && pass_q != LAST) |=>
      (idx_q == '0 && pass_q == $past(pass_q) + 1'b1))
    else $error("pass did not advance");

  assert_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !tick_i && !start_i) |=> ($stable(idx_q) && $stable(pass_q)))
    else $error("index moved without clock enable");

  assert_fast_once_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fast_o |=> !fast_o)
    else $error("two fast cycles in a row");

  assert_done_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && tick_i && idx_q == LAST && pass_q == LAST) |=> (done_o && !busy_o))
    else $error("done not reached");
endmodule

// File: rtl/vct_out_check.sv
module vct_out_check #(
  parameter int OUT_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             active_i,
  input  logic             strobe_i,
  input  logic [OUT_W-1:0] exp_i,
  input  logic [OUT_W-1:0] obs_i,
  output logic             fail_o
);
  logic fail_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                        fail_q <= 1'b0;
    else if (clr_i)                                     fail_q <= 1'b0;
    else if (active_i && strobe_i && (obs_i != exp_i))  fail_q <= 1'b1;
  end

  assign fail_o = fail_q;

  assert_sticky_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fail_q && !clr_i) |=> fail_q)
    else $error("fail flag dropped");

  assert_idle_strobe_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!active_i && !clr_i && !fail_q) |=> !fail_q)
    else $error("fail set outside a run");
endmodule

// File: rtl/vct_sequencer.sv
module vct_sequencer #(
  parameter int NUM_VEC  = 6,
  parameter int VEC_W    = 8,
  parameter int OUT_W    = 4,
  parameter int SLOW_DIV = 4,
  localparam int IDX_W   = $clog2(NUM_VEC)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             ld_we_i,
  input  logic [IDX_W-1:0] ld_addr_i,
  input  logic [VEC_W-1:0] ld_vec_i,
  input  logic [OUT_W-1:0] ld_exp_i,
  input  logic             strobe_i,
  input  logic [OUT_W-1:0] cut_out_i,
  output logic             cut_clk_en_o,
  output logic             fast_o,
  output logic [VEC_W-1:0] cut_vec_o,
  output logic [IDX_W-1:0] pass_o,
  output logic [IDX_W-1:0] idx_o,
  output logic             busy_o,
  output logic             done_o,
  output logic             fail_o
);
  logic             tick, start_ok, busy, fast;
  logic [IDX_W-1:0] idx;
  logic [VEC_W-1:0] rvec;
  logic [OUT_W-1:0] rexp;

  vct_seq_ctrl #(.NUM_VEC(NUM_VEC)) u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start_i),
    .tick_i     (tick),
    .start_ok_o (start_ok),
    .busy_o     (busy),
    .done_o     (done_o),
    .fast_o     (fast),
    .pass_o     (pass_o),
    .idx_o      (idx)
  );

  vct_slot_timer #(.SLOW_DIV(SLOW_DIV)) u_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (busy),
    .fast_i (fast),
    .tick_o (tick)
  );

  vct_vec_mem #(.NUM_VEC(NUM_VEC), .VEC_W(VEC_W), .OUT_W(OUT_W)) u_mem (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (ld_we_i),
    .lock_i  (busy),
    .waddr_i (ld_addr_i),
    .wvec_i  (ld_vec_i),
    .wexp_i  (ld_exp_i),
    .raddr_i (idx),
    .rvec_o  (rvec),
    .rexp_o  (rexp)
  );

  vct_out_check #(.OUT_W(OUT_W)) u_chk (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clr_i    (start_ok),
    .active_i (busy),
    .strobe_i (strobe_i),
    .exp_i    (rexp),
    .obs_i    (cut_out_i),
    .fail_o   (fail_o)
  );

  assign cut_clk_en_o = tick;
  assign fast_o       = fast;
  assign busy_o       = busy;
  assign idx_o        = idx;
  assign cut_vec_o    = busy ? rvec : '0;

  assert_quiet_idle_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> (!cut_clk_en_o && !fast_o && cut_vec_o == '0))
    else $error("activity while idle");

  assert_done_excl_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o)
    else $error("done while busy");

  assert_done_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !start_i) |=> done_o)
    else $error("done dropped without start");
endmodule

// File: tb/tb_vct_sequencer.sv
module tb_vct_sequencer;
  localparam int N  = 6;
  localparam int VW = 8;
  localparam int OW = 4;
  localparam int D  = 4;
  localparam int IW = $clog2(N);

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          start_i = 1'b0, ld_we_i = 1'b0, strobe_i = 1'b0;
  logic [IW-1:0] ld_addr_i = '0;
  logic [VW-1:0] ld_vec_i = '0;
  logic [OW-1:0] ld_exp_i = '0, cut_out_i = '0;
  logic          cut_clk_en_o, fast_o, busy_o, done_o, fail_o;
  logic [VW-1:0] cut_vec_o;
  logic [IW-1:0] pass_o, idx_o;

  logic [VW-1:0] m_vec [N];
  logic [OW-1:0] m_exp [N];
  int checks = 0, failures = 0, cyc = 0;

  vct_sequencer #(.NUM_VEC(N), .VEC_W(VW), .OUT_W(OW), .SLOW_DIV(D)) dut (.*);

  always #4 clk_i = ~clk_i;

  always @(posedge clk_i) begin
    cyc <= cyc + 1;
    if (cyc > 50000) begin
      failures = failures + 1;
      $display("FAIL watchdog act=%0d exp=<50000", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  function automatic int run_len();
    return N * ((N - 1) * D + 1);
  endfunction

  task automatic load_all();
    for (int a = 0; a < N; a++) begin
      m_vec[a] = VW'($urandom);
      m_exp[a] = OW'($urandom);
      @(negedge clk_i);
      ld_we_i = 1'b1; ld_addr_i = IW'(a); ld_vec_i = m_vec[a]; ld_exp_i = m_exp[a];
    end
    @(negedge clk_i);
    ld_we_i = 1'b0;
  endtask

  // bad_k/bad_i: pass and index at which the observed output is corrupted (-1: none)
  task automatic run_seq(input int bad_k, input int bad_i, input bit poke);
    int n = 0;
    @(negedge clk_i);
    start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    chk(fail_o == 1'b0, "R2 fail cleared", fail_o, 0);
    for (int k = 0; k < N; k++) begin
      for (int i = 0; i < N; i++) begin
        int len = (i == k) ? 1 : D;
        for (int c = 0; c < len; c++) begin
          bit corrupt = (k == bad_k) && (i == bad_i) && (c == 0);
          chk(busy_o && !done_o, "R2 busy", busy_o, 1);
          chk(pass_o == IW'(k) && idx_o == IW'(i), "R5 pass/idx",
              int'(pass_o) * 16 + int'(idx_o), k * 16 + i);
          chk(fast_o == (i == k), (i == k) ? "R3 fast" : "R4 slow", fast_o, int'(i == k));
          chk(cut_clk_en_o == (c == len - 1), (i == k) ? "R3 enable" : "R4 enable",
              cut_clk_en_o, int'(c == len - 1));
          chk(cut_vec_o == m_vec[i], "R7 vector", cut_vec_o, m_vec[i]);
          strobe_i  = corrupt ? 1'b1 : 1'($urandom);
          cut_out_i = corrupt ? ~m_exp[i] : m_exp[i];
          if (poke && k == 1 && i == 2 && c == 0) begin
            ld_we_i = 1'b1; ld_addr_i = '0; ld_vec_i = ~m_vec[0]; ld_exp_i = ~m_exp[0];
            start_i = 1'b1;
          end
          n++;
          @(negedge clk_i);
          ld_we_i = 1'b0; start_i = 1'b0; strobe_i = 1'b0;
        end
      end
    end
    chk(n == run_len(), "R6 length", n, run_len());
    chk(done_o && !busy_o, "R6 done", done_o, 1);
    chk(fail_o == (bad_k >= 0), "R9 fail", fail_o, int'(bad_k >= 0));
    chk(cut_vec_o == '0 && !cut_clk_en_o, "R7 idle vector", cut_vec_o, 0);
  endtask

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk_i);
    chk(!busy_o && !done_o && !fail_o, "R1 flags", {busy_o, done_o, fail_o}, 0);
    chk(!fast_o && !cut_clk_en_o, "R1 timing", {fast_o, cut_clk_en_o}, 0);
    chk(cut_vec_o == '0 && pass_o == '0 && idx_o == '0, "R1 counters", cut_vec_o, 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk(!busy_o && !done_o, "R1 idle after reset", busy_o, 0);

    load_all();
    run_seq(-1, -1, 1'b0);                        // clean run
    run_seq(2, 4, 1'b1);                          // mismatch, plus mid-run load/start (R8, R2)
    // R9: strobe after the run with a wrong value, fail already set, then clean run clears it
    @(negedge clk_i);
    strobe_i = 1'b1; cut_out_i = ~m_exp[0];
    @(negedge clk_i);
    strobe_i = 1'b0;
    chk(fail_o == 1'b1 && done_o, "R6 done held", {fail_o, done_o}, 3);
    run_seq(-1, -1, 1'b0);
    // R9: idle strobe with mismatch does not set fail
    repeat (3) begin
      @(negedge clk_i);
      strobe_i = 1'b1; cut_out_i = ~m_exp[idx_o];
    end
    @(negedge clk_i);
    strobe_i = 1'b0;
    chk(fail_o == 1'b0, "R9 idle strobe ignored", fail_o, 0);
    // corner: mismatch at the very first rated vector and at the final vector
    load_all();
    run_seq(0, 0, 1'b0);
    run_seq(N - 1, N - 1, 1'b0);
    // R8: fresh contents after idle reload are used
    load_all();
    run_seq(-1, -1, 1'b0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule